// File: doc/BRIEF.md
# Chainable Decimal Digit Up/Down Counter

This block holds one decimal digit (0 to 9) and steps it up or down by one on each clock edge when its active-low count enable is low. A direction input picks the sense: low counts up, high counts down. The digit wraps at both ends, so 9 goes to 0 when counting up and 0 goes to 9 when counting down. An active-low load input presets the digit from a 4-bit value on the next edge. Load wins over counting.

Two flags serve chaining. The terminal flag is high when the digit sits at the last value for the current direction: 9 going up, 0 going down. The active-low ripple output goes low when the digit is at that value and the counter is enabled. Wiring one digit's ripple output to the next digit's count enable builds a multi-digit decimal counter with no added gates, because the higher digit then steps on the same edge on which the lower digit wraps.

All state changes happen on the rising edge of the one system clock. A synchronous active-high reset clears the digit to 0.

Top module: `bcd_updown_digit`

## Requirements
- R1: While reset is high at a rising edge, the digit becomes 0 on that edge.
- R2: With load high, enable low and direction low, the digit rises by one on each edge, and 9 is followed by 0.
- R3: With load high, enable low and direction high, the digit falls by one on each edge, and 0 is followed by 9.
- R4: With load high and enable high, the digit keeps its value, whatever the direction input is.
- R5: With load low, the digit takes the 4-bit load value on the next edge, whatever the enable and direction inputs are.
- R6: The terminal flag is high exactly when the digit is 9 with direction low, or 0 with direction high. It is combinational from the current digit and direction.
- R7: The ripple output is low exactly when the terminal flag is high and the enable is low. Otherwise it is high. It is combinational.
- R8: A digit holding a loaded value from 10 to 15 becomes 0 on the next counting edge, in either direction. Such a value never raises the terminal flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en_n | input | 1 | Count enable, active low |
| dir_down | input | 1 | Direction select: 1 counts down, 0 counts up |
| load_n | input | 1 | Parallel preset, active low |
| load_val | input | 4 | Value taken when load is low |
| digit_q | output | 4 | Current digit |
| term_cnt | output | 1 | High at 9 going up or at 0 going down |
| ripple_n | output | 1 | Low at terminal while enabled; drives the next digit's enable |

## Verification
A wrong stored digit shows at `digit_q` one edge after the stimulus that caused it. The same fault also corrupts `term_cnt` and `ripple_n` in that same cycle, but only when the bad value meets the terminal condition for the current direction. A wrong wrap or a wrong non-decimal recovery therefore appears either at once as a wrong digit, or on the following edge as a missing or extra ripple pulse. In a chain, that ripple error would step the neighbouring digit wrongly. The bench compares all three outputs in every cycle against a model driven by both random and directed stimulus, so any such divergence is caught within one clock.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;

    localparam int BCD_W = 4;

    typedef logic [BCD_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t digit;
    } digit_state_t;

endpackage

// File: rtl/bcd_step_logic.sv
module bcd_step_logic
    import bcd_cnt_pkg::*;
#(
    parameter int LAST = 9
) (
    input  bcd_t cur,
    input  logic dir_down,
    output bcd_t nxt
);
    localparam bcd_t LAST_V = bcd_t'(LAST);

    always_comb begin
        if (cur > LAST_V) begin
            nxt = '0;
        end else if (dir_down) begin
            nxt = (cur == '0) ? LAST_V : cur - bcd_t'(1);
        end else begin
            nxt = (cur == LAST_V) ? '0 : cur + bcd_t'(1);
        end
    end
endmodule

// File: rtl/bcd_term_logic.sv
module bcd_term_logic
    import bcd_cnt_pkg::*;
#(
    parameter int LAST = 9
) (
    input  bcd_t cur,
    input  logic dir_down,
    input  logic cnt_en_n,
    output logic term,
    output logic ripple_n
);
    localparam bcd_t LAST_V = bcd_t'(LAST);

    always_comb begin
        term     = dir_down ? (cur == '0) : (cur == LAST_V);
        ripple_n = ~(term & ~cnt_en_n);
    end
endmodule

// File: rtl/bcd_updown_digit.sv
module bcd_updown_digit
    import bcd_cnt_pkg::*;
#(
    parameter int LAST = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en_n,
    input  logic             dir_down,
    input  logic             load_n,
    input  logic [BCD_W-1:0] load_val,
    output logic [BCD_W-1:0] digit_q,
    output logic             term_cnt,
    output logic             ripple_n
);
    localparam bcd_t LAST_V = bcd_t'(LAST);

    digit_state_t st_d, st_q;
    bcd_t         step_d;

    bcd_step_logic #(.LAST(LAST)) u_step (
        .cur      (st_q.digit),
        .dir_down (dir_down),
        .nxt      (step_d)
    );

    bcd_term_logic #(.LAST(LAST)) u_term (
        .cur      (st_q.digit),
        .dir_down (dir_down),
        .cnt_en_n (cnt_en_n),
        .term     (term_cnt),
        .ripple_n (ripple_n)
    );

    always_comb begin
        st_d = st_q;
        if (!load_n) begin
            st_d.digit = load_val;
        end else if (!cnt_en_n) begin
            st_d.digit = step_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign digit_q = st_q.digit;

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> digit_q == '0); // R1
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && !dir_down && digit_q == LAST_V) |=> digit_q == '0); // R2
    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && dir_down && digit_q == '0) |=> digit_q == LAST_V); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (load_n && cnt_en_n) |=> $stable(digit_q)); // R4
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> digit_q == $past(load_val)); // R5
    AST_TERM_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        term_cnt |-> digit_q <= LAST_V); // R6
    AST_RIPPLE_AT_TERM: assert property (@(posedge clk) disable iff (rst)
        !ripple_n |-> (term_cnt && !cnt_en_n)); // R7
    AST_NONBCD_RECOVER: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && digit_q > LAST_V) |=> digit_q == '0); // R8
endmodule

// File: tb/bcd_updown_digit_tb.sv
module bcd_updown_digit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en_n = 1'b1;
    logic       dir_down = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] load_val = 4'd0;
    logic [3:0] digit_q;
    logic       term_cnt;
    logic       ripple_n;

    int   n_run  = 0;
    int   n_fail = 0;
    logic [3:0] exp_q = 4'd0;

    always #4 clk = ~clk;

    bcd_updown_digit u_dut (
        .clk(clk), .rst(rst), .cnt_en_n(cnt_en_n), .dir_down(dir_down),
        .load_n(load_n), .load_val(load_val), .digit_q(digit_q),
        .term_cnt(term_cnt), .ripple_n(ripple_n)
    );

    function automatic logic [3:0] model_next(input logic [3:0] cur, input logic r,
        input logic en_n, input logic dn, input logic ld_n, input logic [3:0] v);
        if (r) return 4'd0;
        if (!ld_n) return v;
        if (en_n) return cur;
        if (cur > 4'd9) return 4'd0;
        if (dn) return (cur == 4'd0) ? 4'd9 : cur - 4'd1;
        return (cur == 4'd9) ? 4'd0 : cur + 4'd1;
    endfunction

    function automatic logic model_term(input logic [3:0] cur, input logic dn);
        return dn ? (cur == 4'd0) : (cur == 4'd9);
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive at negedge, check flags, clock, then check the registered digit.
    task automatic step(input logic r, input logic en_n, input logic dn,
                        input logic ld_n, input logic [3:0] v);
        string tag;
        logic  t;
        rst = r; cnt_en_n = en_n; dir_down = dn; load_n = ld_n; load_val = v;
        #1;
        t = model_term(exp_q, dn);
        check("R6 term", {3'b0, term_cnt}, {3'b0, t});
        check("R7 ripple", {3'b0, ripple_n}, {3'b0, ~(t & ~en_n)});
        if (r)              tag = "R1 reset";
        else if (!ld_n)     tag = "R5 load";
        else if (en_n)      tag = "R4 hold";
        else if (exp_q > 9) tag = "R8 nonbcd";
        else if (dn)        tag = "R3 down";
        else                tag = "R2 up";
        exp_q = model_next(exp_q, r, en_n, dn, ld_n, v);
        @(posedge clk);
        @(negedge clk);
        check(tag, digit_q, exp_q);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        exp_q = 4'd7;
        @(negedge clk);
        step(1'b1, 1'b0, 1'b0, 1'b1, 4'd5);              // R1
        // R2: up through the wrap
        for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 1'b0, 1'b1, 4'd0);
        // R3: down through the wrap
        for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 1'b1, 1'b1, 4'd0);
        // R4: hold with either direction
        step(1'b0, 1'b1, 1'b0, 1'b1, 4'd3);
        step(1'b0, 1'b1, 1'b1, 1'b1, 4'd3);
        // R5: load overrides enable, and loads with enable high
        step(1'b0, 1'b0, 1'b1, 1'b0, 4'd9);
        step(1'b0, 1'b1, 1'b0, 1'b1, 4'd0);              // R7: terminal, disabled
        step(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
        step(1'b0, 1'b1, 1'b1, 1'b1, 4'd0);              // R7: terminal down, disabled
        // R8: non-decimal recovery in both directions
        step(1'b0, 1'b0, 1'b0, 1'b0, 4'd12);
        step(1'b0, 1'b0, 1'b0, 1'b1, 4'd0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 4'd15);
        step(1'b0, 1'b1, 1'b1, 1'b1, 4'd0);              // R6: no terminal at 15
        step(1'b0, 1'b0, 1'b1, 1'b1, 4'd0);
        step(1'b0, 1'b0, 1'b1, 1'b0, 4'd10);
        step(1'b0, 1'b0, 1'b1, 1'b1, 4'd0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] r8;
            r8 = 8'($urandom);
            step((r8 < 3), ($urandom % 4) == 0, 1'($urandom),
                 ($urandom % 8) != 0, 4'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule